// File: doc/BRIEF.md
# Scatter-Gather Copy Engine

This block copies data from card-side addresses to host-side addresses by walking a list of transfer descriptors kept in memory. Software gives it the address of the first descriptor and pulses a start input. The engine then reads each descriptor, one word at a time, over a word-wide read port. It moves the byte count that the descriptor describes one 32-bit word at a time, with a read through the read port followed by a write through the write port. After the copy it goes on to the next descriptor, until it completes one that carries the end-of-list marker.

A descriptor is three consecutive words. The first word is the source address. The second word is the destination address. The third word is a control word: a byte count in bits [17:0] and an end-of-list marker in bit 31. Every list ends with a one-cycle interrupt pulse. A five-bit sticky status vector records how the list ended. Software clears status bits by writing ones to them. Words pass through unchanged as little-endian 32-bit values, with byte 0 in bits [7:0].

Top module: `sg_copy_engine`

## Requirements
- R1: After a start, the engine reads the three words of each descriptor at addresses P, P+4 and P+8, in that order. P is the descriptor pointer. Bits [30:18] of the control word have no effect.
- R2: A valid descriptor copies count/4 words in order. Each word is read from the source address and written unchanged to the destination address, and both addresses advance by 4 after each word. Exactly one of the read and write requests is active at a time.
- R3: If the end-of-list bit (bit 31) of the finished descriptor is clear, the next descriptor is read at P+12. The first descriptor is at the programmed base address.
- R4: A control word whose count is zero, or whose bits [7:0] are not all zero, ends the list. It sets status bit 4 and moves no data for that descriptor. Data moved by earlier descriptors stays.
- R5: An error response on the read port ends the list at once and sets status bit 2. This applies to a descriptor read and to a data read, and no further read or write follows.
- R6: An error response on the write port ends the list at once and sets status bit 3.
- R7: A list that completes its end-of-list descriptor without error sets status bit 0 (read done) and status bit 1 (write done).
- R8: Each list ends with exactly one irq pulse one cycle wide. busy is low from the cycle in which irq is high.
- R9: Status bits stay set until software clears them. Asserting sts_clr clears exactly the bits that are set in sts_clr_mask.
- R10: A start pulse received while busy is high is ignored. The running list completes unchanged.
- R11: After reset, status is 0 and busy, irq, rd_req and wr_req are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | 32 | Byte address of the first descriptor |
| cfg_start | input | 1 | Start pulse, one cycle |
| sts_clr | input | 1 | Status clear strobe |
| sts_clr_mask | input | 5 | Status bits to clear when sts_clr is high |
| status | output | 5 | Sticky status: 0 read done, 1 write done, 2 read error, 3 write error, 4 descriptor error |
| busy | output | 1 | A list is in progress |
| irq | output | 1 | One-cycle end-of-list pulse |
| rd_req | output | 1 | Read request, held until rd_ack |
| rd_addr | output | 32 | Read byte address |
| rd_ack | input | 1 | Read response valid, one cycle |
| rd_data | input | 32 | Read data, valid with rd_ack |
| rd_err | input | 1 | Read error, valid with rd_ack |
| wr_req | output | 1 | Write request, held until wr_ack |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write response, one cycle |
| wr_err | input | 1 | Write error, valid with wr_ack |

## Verification
The cases that are hardest to reach from the ports are the aborts in the middle of a list. These are an error on the third descriptor word, an error on one specific data word partway through a later descriptor, and a start pulse that arrives while a copy is running. The bench's memory model returns an error whenever the request address equals a chosen address. This lets a random list fail at any descriptor or any word. A start pulse is driven on a fixed cycle count into a long list, together with a base address pointing at a different list. The bench's own model walks the same descriptors to predict the final memory contents and the final status.

// File: rtl/sg_copy_pkg.sv
// Shared types for the scatter-gather copy engine.
// Assumes a five-bit status vector with the bit order used at the top level.
package sg_copy_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_SRC,
        ST_GET_DST,
        ST_GET_CTL,
        ST_CHECK,
        ST_READ,
        ST_WRITE
    } sg_state_e;

    localparam int STAT_W       = 5;
    localparam int STAT_RD_DONE = 0;
    localparam int STAT_WR_DONE = 1;
    localparam int STAT_RD_ERR  = 2;
    localparam int STAT_WR_ERR  = 3;
    localparam int STAT_SG_ERR  = 4;
endpackage

// File: rtl/sg_ctl_decode.sv
// Splits a descriptor control word into its byte count and end-of-list flag,
// and flags a count that is zero or not a multiple of 2**ALIGN_LG.
// Assumes the end-of-list flag is the top bit of the word.
module sg_ctl_decode #(
    parameter int DW       = 32,
    parameter int CNT_W    = 18,
    parameter int ALIGN_LG = 8
) (
    input  logic [DW-1:0]    ctl_word,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             end_flag,
    output logic             malformed
);
    logic unused_rsvd;

    // Field extraction; the reserved bits between count and flag are dropped.
    always_comb begin
        byte_cnt    = ctl_word[CNT_W-1:0];
        end_flag    = ctl_word[DW-1];
        unused_rsvd = ^ctl_word[DW-2:CNT_W];
        malformed   = (byte_cnt == '0) || (byte_cnt[ALIGN_LG-1:0] != '0);
    end
endmodule

// File: rtl/sg_word_walker.sv
// Holds the source and destination addresses and the number of words left
// for the descriptor being copied. Assumes load and step never coincide.
module sg_word_walker #(
    parameter int AW    = 32,
    parameter int CNT_W = 18,
    parameter int WB    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [AW-1:0]    load_src,
    input  logic [AW-1:0]    load_dst,
    input  logic [CNT_W-1:0] load_bytes,
    input  logic             step,
    output logic [AW-1:0]    src_addr,
    output logic [AW-1:0]    dst_addr,
    output logic             final_word
);
    localparam int WB_LG = $clog2(WB);
    localparam int WL_W  = CNT_W - WB_LG;
    localparam logic [AW-1:0] WSTEP = AW'(WB);

    logic [WL_W-1:0] words_left;

    // Address and remaining-word bookkeeping for the current descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_addr   <= '0;
            dst_addr   <= '0;
            words_left <= '0;
        end else if (load) begin
            src_addr   <= load_src;
            dst_addr   <= load_dst;
            words_left <= load_bytes[CNT_W-1:WB_LG];
        end else if (step) begin
            src_addr   <= src_addr + WSTEP;
            dst_addr   <= dst_addr + WSTEP;
            words_left <= words_left - 1'b1;
        end
    end

    // Last-word indication for the descriptor in progress.
    always_comb final_word = (words_left == WL_W'(1));

    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (words_left != '0));
endmodule

// File: rtl/sg_status_bits.sv
// Sticky status bits: a set input wins over a clear in the same cycle.
// Assumes clr_mask is only meaningful while clr is high.
module sg_status_bits #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        // One sticky, write-one-to-clear bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                   status[b] <= 1'b0;
            else if (set_vec[b])          status[b] <= 1'b1;
            else if (clr && clr_mask[b])  status[b] <= 1'b0;
        end

        assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (status[b] && !(clr && clr_mask[b])) |=> status[b]);
    end
endmodule

// File: rtl/sg_copy_engine.sv
// Scatter-gather copy engine top. Reads three-word descriptors from a list,
// copies each one word by word through the read and write ports, and ends
// the list on an end-of-list descriptor, a malformed count or a port error.
// Assumes each port responds with a single-cycle ack while its req is held.
module sg_copy_engine
    import sg_copy_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int CNT_W    = 18,
    parameter int ALIGN_LG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cfg_base,
    input  logic              cfg_start,
    input  logic              sts_clr,
    input  logic [STAT_W-1:0] sts_clr_mask,
    output logic [STAT_W-1:0] status,
    output logic              busy,
    output logic              irq,
    output logic              rd_req,
    output logic [AW-1:0]     rd_addr,
    input  logic              rd_ack,
    input  logic [DW-1:0]     rd_data,
    input  logic              rd_err,
    output logic              wr_req,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    input  logic              wr_ack,
    input  logic              wr_err
);
    localparam int WB = DW / 8;
    localparam logic [AW-1:0] OFS_DST   = AW'(WB);
    localparam logic [AW-1:0] OFS_CTL   = AW'(2 * WB);
    localparam logic [AW-1:0] DESC_STEP = AW'(3 * WB);

    sg_state_e         state_q;
    logic [AW-1:0]     ptr_q;
    logic [AW-1:0]     src_w_q;
    logic [AW-1:0]     dst_w_q;
    logic [DW-1:0]     ctl_w_q;
    logic [DW-1:0]     data_q;
    logic              irq_q;

    logic [CNT_W-1:0]  byte_cnt;
    logic              end_flag;
    logic              malformed;
    logic [AW-1:0]     cur_src;
    logic [AW-1:0]     cur_dst;
    logic              final_word;
    logic              walk_load;
    logic              walk_step;

    logic              rd_fail;
    logic              wr_fail;
    logic              sg_fail;
    logic              list_ok;
    logic              end_evt;
    logic [STAT_W-1:0] set_vec;

    sg_ctl_decode #(.DW(DW), .CNT_W(CNT_W), .ALIGN_LG(ALIGN_LG)) u_decode (
        .ctl_word  (ctl_w_q),
        .byte_cnt  (byte_cnt),
        .end_flag  (end_flag),
        .malformed (malformed)
    );

    sg_word_walker #(.AW(AW), .CNT_W(CNT_W), .WB(WB)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (walk_load),
        .load_src   (src_w_q),
        .load_dst   (dst_w_q),
        .load_bytes (byte_cnt),
        .step       (walk_step),
        .src_addr   (cur_src),
        .dst_addr   (cur_dst),
        .final_word (final_word)
    );

    sg_status_bits #(.W(STAT_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr      (sts_clr),
        .clr_mask (sts_clr_mask),
        .status   (status)
    );

    // Port requests and addresses decoded from the current state.
    always_comb begin
        rd_req  = 1'b0;
        rd_addr = ptr_q;
        unique case (state_q)
            ST_GET_SRC: begin rd_req = 1'b1; rd_addr = ptr_q; end
            ST_GET_DST: begin rd_req = 1'b1; rd_addr = ptr_q + OFS_DST; end
            ST_GET_CTL: begin rd_req = 1'b1; rd_addr = ptr_q + OFS_CTL; end
            ST_READ:    begin rd_req = 1'b1; rd_addr = cur_src; end
            default:    ;
        endcase
        wr_req  = (state_q == ST_WRITE);
        wr_addr = cur_dst;
        wr_data = data_q;
        busy    = (state_q != ST_IDLE);
        irq     = irq_q;
    end

    // End-of-list events and the status bits they set.
    always_comb begin
        rd_fail   = rd_req && rd_ack && rd_err;
        wr_fail   = wr_req && wr_ack && wr_err;
        sg_fail   = (state_q == ST_CHECK) && malformed;
        walk_load = (state_q == ST_CHECK) && !malformed;
        walk_step = wr_req && wr_ack && !wr_err;
        list_ok   = walk_step && final_word && end_flag;
        end_evt   = rd_fail || wr_fail || sg_fail || list_ok;
        set_vec               = '0;
        set_vec[STAT_RD_DONE] = list_ok;
        set_vec[STAT_WR_DONE] = list_ok;
        set_vec[STAT_RD_ERR]  = rd_fail;
        set_vec[STAT_WR_ERR]  = wr_fail;
        set_vec[STAT_SG_ERR]  = sg_fail;
    end

    // Sequencer: descriptor fetch, check, then read/write per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            src_w_q <= '0;
            dst_w_q <= '0;
            ctl_w_q <= '0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cfg_start) begin
                    ptr_q   <= cfg_base;
                    state_q <= ST_GET_SRC;
                end
                ST_GET_SRC: if (rd_ack) begin
                    src_w_q <= rd_data;
                    state_q <= rd_err ? ST_IDLE : ST_GET_DST;
                end
                ST_GET_DST: if (rd_ack) begin
                    dst_w_q <= rd_data;
                    state_q <= rd_err ? ST_IDLE : ST_GET_CTL;
                end
                ST_GET_CTL: if (rd_ack) begin
                    ctl_w_q <= rd_data;
                    state_q <= rd_err ? ST_IDLE : ST_CHECK;
                end
                ST_CHECK: state_q <= malformed ? ST_IDLE : ST_READ;
                ST_READ: if (rd_ack) begin
                    data_q  <= rd_data;
                    state_q <= rd_err ? ST_IDLE : ST_WRITE;
                end
                ST_WRITE: if (wr_ack) begin
                    if (wr_err) begin
                        state_q <= ST_IDLE;
                    end else if (!final_word) begin
                        state_q <= ST_READ;
                    end else if (end_flag) begin
                        state_q <= ST_IDLE;
                    end else begin
                        ptr_q   <= ptr_q + DESC_STEP;
                        state_q <= ST_GET_SRC;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // One-cycle interrupt on any end of list.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= end_evt;
    end

    assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);
    assert_rd_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_err) |=> (!busy && status[STAT_RD_ERR]));
    assert_wr_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack && wr_err) |=> (!busy && status[STAT_WR_ERR]));
    assert_done_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        list_ok |=> (status[STAT_RD_DONE] && status[STAT_WR_DONE] && irq));
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_start && busy && state_q != ST_WRITE) |=> $stable(ptr_q));
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req && !wr_req));
endmodule

// File: tb/sg_copy_engine_test.sv
// Self-checking bench: memory model with address-matched error injection,
// directed corner cases and seeded random descriptor lists.
module sg_copy_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;
    localparam int RUN_LIMIT  = 20000;
    localparam logic [31:0] NO_ERR = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base = '0;
    logic        cfg_start = 1'b0;
    logic        sts_clr = 1'b0;
    logic [4:0]  sts_clr_mask = '0;
    logic [4:0]  status;
    logic        busy, irq, rd_req, wr_req;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic        rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
    logic [31:0] rd_data = '0;

    logic [31:0] mem     [0:MEM_WORDS-1];
    logic [31:0] exp_mem [0:MEM_WORDS-1];
    logic [31:0] err_rd_addr = NO_ERR;
    logic [31:0] err_wr_addr = NO_ERR;
    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sg_copy_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_start(cfg_start),
        .sts_clr(sts_clr), .sts_clr_mask(sts_clr_mask), .status(status),
        .busy(busy), .irq(irq),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err)
    );

    function automatic int wi(input logic [31:0] a);
        return int'(a[13:2]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Memory responder: one-cycle acks after 0 or 1 wait cycles, driven at negedge.
    initial begin
        int rd_dly = 0;
        int wr_dly = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rd_ack) begin
                rd_ack = 1'b0; rd_err = 1'b0; rd_dly = $urandom_range(0, 1);
            end else if (rd_req) begin
                if (rd_dly == 0) begin
                    rd_ack  = 1'b1;
                    rd_data = mem[wi(rd_addr)];
                    rd_err  = (rd_addr == err_rd_addr);
                end else rd_dly--;
            end
            if (wr_ack) begin
                wr_ack = 1'b0; wr_err = 1'b0; wr_dly = $urandom_range(0, 1);
            end else if (wr_req) begin
                if (wr_dly == 0) begin
                    wr_ack = 1'b1;
                    wr_err = (wr_addr == err_wr_addr);
                    if (!wr_err) mem[wi(wr_addr)] = wr_data;
                end else wr_dly--;
            end
        end
    end

    // Global watchdog.
    initial begin
        #(CLK_PERIOD * 190000);
        fails++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Reference walk of the list over exp_mem; returns the expected status.
    task automatic model(input logic [31:0] base, output logic [4:0] st);
        logic [31:0] ptr = base;
        st = 5'h00;
        for (int d = 0; d < 64; d++) begin
            logic [31:0] w [3];
            logic [17:0] cnt;
            logic [31:0] s, t;
            for (int k = 0; k < 3; k++) begin
                if (ptr + 32'(4*k) == err_rd_addr) begin st = 5'h04; return; end
                w[k] = exp_mem[wi(ptr + 32'(4*k))];
            end
            cnt = w[2][17:0];
            if (cnt == 0 || cnt[7:0] != 0) begin st = 5'h10; return; end
            s = w[0]; t = w[1];
            for (int j = 0; j < int'(cnt) / 4; j++) begin
                if (s == err_rd_addr) begin st = 5'h04; return; end
                if (t == err_wr_addr) begin st = 5'h08; return; end
                exp_mem[wi(t)] = exp_mem[wi(s)];
                s += 4; t += 4;
            end
            if (w[2][31]) begin st = 5'h03; return; end
            ptr += 12;
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] s, input logic [31:0] t,
                            input logic [31:0] ctl);
        mem[wi(a)] = s; mem[wi(a + 4)] = t; mem[wi(a + 8)] = ctl;
    endtask

    function automatic logic [31:0] ctl_w(input bit last, input logic [17:0] cnt, input logic [12:0] rsv);
        return {last, rsv, cnt};
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = $urandom;
    endtask

    // Runs one list and checks status, irq shape and memory contents.
    task automatic run_list(input logic [31:0] base, input bit keep_status, input logic [4:0] prior,
                            input int early, input string req);
        logic [4:0] exp_st;
        int n;
        int bad_words = 0;
        for (int i = 0; i < MEM_WORDS; i++) exp_mem[i] = mem[i];
        model(base, exp_st);
        if (keep_status) exp_st |= prior;
        if (!keep_status) begin
            @(negedge clk); sts_clr = 1'b1; sts_clr_mask = 5'h1F;
            @(negedge clk); sts_clr = 1'b0; sts_clr_mask = 5'h00;
        end
        cfg_base = base; cfg_start = 1'b1;
        @(negedge clk); cfg_start = 1'b0;
        for (n = 0; n < RUN_LIMIT; n++) begin
            if (irq) break;
            if (n == early && busy) begin cfg_base = 32'h0000_0F00; cfg_start = 1'b1; end
            else cfg_start = 1'b0;
            @(negedge clk);
        end
        cfg_start = 1'b0;
        if (n == RUN_LIMIT) begin
            chk(1'b0, {req, " run timeout"}, 32'(n), 32'(RUN_LIMIT));
            return;
        end
        chk(!busy, "R8 busy low with irq", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(!irq, "R8 irq one cycle", {31'd0, irq}, 32'd0);
        chk(status == exp_st, {req, " status"}, {27'd0, status}, {27'd0, exp_st});
        for (int i = 0; i < MEM_WORDS; i++) if (mem[i] !== exp_mem[i]) bad_words++;
        chk(bad_words == 0, {req, " R2 memory contents"}, 32'(bad_words), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fill_mem();
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(status == 5'h00, "R11 status", {27'd0, status}, 32'd0);
        chk(!busy && !irq, "R11 busy/irq", {30'd0, busy, irq}, 32'd0);
        chk(!rd_req && !wr_req, "R11 requests", {30'd0, rd_req, wr_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R7: single descriptor with end-of-list.
        put_desc(32'h100, 32'h1000, 32'h2000, ctl_w(1'b1, 18'd256, 13'd0));
        run_list(32'h100, 1'b0, 5'h0, -1, "R7 single");

        // R1 R3: three descriptors, reserved bits set, chained at +12.
        fill_mem();
        put_desc(32'h200, 32'h1100, 32'h2400, ctl_w(1'b0, 18'd512, 13'h1FFF));
        put_desc(32'h20C, 32'h1800, 32'h2800, ctl_w(1'b0, 18'd256, 13'h0AAA));
        put_desc(32'h218, 32'h1C00, 32'h3000, ctl_w(1'b1, 18'd768, 13'h1555));
        run_list(32'h200, 1'b0, 5'h0, -1, "R1 R3 chain");

        // R4: zero count on the second descriptor.
        fill_mem();
        put_desc(32'h300, 32'h1000, 32'h2000, ctl_w(1'b0, 18'd256, 13'd0));
        put_desc(32'h30C, 32'h1400, 32'h2400, ctl_w(1'b1, 18'd0, 13'd0));
        run_list(32'h300, 1'b0, 5'h0, -1, "R4 zero count");

        // R4: count not a multiple of 256.
        fill_mem();
        put_desc(32'h340, 32'h1000, 32'h2000, ctl_w(1'b1, 18'h140, 13'd0));
        run_list(32'h340, 1'b0, 5'h0, -1, "R4 misaligned count");

        // R5: read error on a data word in the second descriptor.
        fill_mem();
        put_desc(32'h400, 32'h1000, 32'h2000, ctl_w(1'b0, 18'd256, 13'd0));
        put_desc(32'h40C, 32'h1400, 32'h2400, ctl_w(1'b1, 18'd512, 13'd0));
        err_rd_addr = 32'h1400 + 32'd40;
        run_list(32'h400, 1'b0, 5'h0, -1, "R5 data read error");
        // R5: read error on the control word of the second descriptor.
        err_rd_addr = 32'h40C + 32'd8;
        run_list(32'h400, 1'b0, 5'h0, -1, "R5 descriptor read error");
        err_rd_addr = NO_ERR;

        // R6: write error partway through.
        fill_mem();
        put_desc(32'h500, 32'h1000, 32'h2000, ctl_w(1'b1, 18'd512, 13'd0));
        err_wr_addr = 32'h2000 + 32'd100;
        run_list(32'h500, 1'b0, 5'h0, -1, "R6 write error");
        err_wr_addr = NO_ERR;

        // R10: start with another base while busy is ignored.
        fill_mem();
        put_desc(32'h600, 32'h1000, 32'h2000, ctl_w(1'b0, 18'd1024, 13'd0));
        put_desc(32'h60C, 32'h1400, 32'h2400, ctl_w(1'b1, 18'd1024, 13'd0));
        put_desc(32'hF00, 32'h1800, 32'h3800, ctl_w(1'b1, 18'd256, 13'd0));
        run_list(32'h600, 1'b0, 5'h0, 30, "R10 start while busy");

        // R9: write-one-to-clear of bit 0 only, then sticky across a new list.
        put_desc(32'h100, 32'h1000, 32'h2000, ctl_w(1'b1, 18'd256, 13'd0));
        run_list(32'h100, 1'b0, 5'h0, -1, "R9 setup");
        @(negedge clk); sts_clr = 1'b1; sts_clr_mask = 5'h01;
        @(negedge clk); sts_clr = 1'b0; sts_clr_mask = 5'h00;
        chk(status == 5'h02, "R9 clear bit 0 only", {27'd0, status}, 32'h02);
        put_desc(32'h700, 32'h1000, 32'h2000, ctl_w(1'b1, 18'd0, 13'd0));
        run_list(32'h700, 1'b1, 5'h02, -1, "R9 sticky");

        // Random lists with occasional injected faults.
        for (int r = 0; r < 20; r++) begin
            logic [31:0] base = 32'(4 * $urandom_range(0, 600));
            int nd = $urandom_range(1, 4);
            int kind = $urandom_range(0, 5);
            int victim = $urandom_range(0, nd - 1);
            fill_mem();
            for (int i = 0; i < nd; i++) begin
                logic [17:0] cnt = 18'(256 * $urandom_range(1, 2));
                logic [31:0] s = 32'h1000 + 32'(4 * $urandom_range(0, (4096 - int'(cnt)) / 4));
                logic [31:0] t = 32'h2000 + 32'(4 * $urandom_range(0, (8192 - int'(cnt)) / 4));
                if (i == victim && kind == 0) err_rd_addr = s + 32'(4 * $urandom_range(0, int'(cnt) / 4 - 1));
                if (i == victim && kind == 1) err_wr_addr = t + 32'(4 * $urandom_range(0, int'(cnt) / 4 - 1));
                if (i == victim && kind == 2) cnt = cnt | 18'h040;
                put_desc(base + 32'(12 * i), s, t, ctl_w(i == nd - 1, cnt, 13'($urandom)));
            end
            run_list(base, 1'b0, 5'h0, -1, "R2 R3 random");
            err_rd_addr = NO_ERR;
            err_wr_addr = NO_ERR;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule